// File: doc/BRIEF.md
# Clip-Limit Histogram Redistribution Engine

This block takes the histogram of one image tile that has already been clipped, together with the total count that clipping removed and the clip limit. It hands that removed count back to the bins without letting any bin rise above the limit. The histogram arrives one bin per cycle in ascending bin order. The redistributed histogram leaves the same way, once all the passes have finished. Cumulative sums and the mapping tables built from them belong to a later stage.

The work is done in a fixed series of serial passes. A load pass stores the incoming bins and counts the bins already at the limit. A serial divider then gives the average increment `m`: the removed count divided by the number of bins below the limit. A first fill pass offers each bin below the limit `m+1` units, taken from a running pool that starts at the removed count. A fixed number of single-unit passes follow. Each pass reads the histogram written by the pass before it and writes a buffer of its own. Any count still in the pool after the last pass is dropped.

Top module: `clahe_redist`

## Requirements
- R1: After reset, `out_valid_o`, `out_last_o` and `done_o` are all low.
- R2: A `start_i` pulse while idle captures `excess_i` and `beta_i`. The next `NBINS` cycles with `in_valid_i` high are taken as bins 0 to `NBINS-1`. With zero excess, the output histogram equals the input.
- R3: The increment `m` is the integer quotient of the excess divided by the number of input bins below the limit. It is 0 when no bin is below the limit, and then every bin comes out unchanged.
- R4: In the first fill pass, bins are visited in ascending order. A bin below the limit gains the smallest of `m+1`, its distance to the limit, and the pool still remaining. A bin at or above the limit is left unchanged. Each gain is taken out of the pool.
- R5: `NFILL` (default 3) further passes follow, each in ascending bin order. Each adds 1 to a bin below the limit while the pool is non-zero, and takes 1 from the pool for each addition.
- R6: For inputs no larger than the limit, no output bin exceeds the limit.
- R7: The pool never grows. Whatever remains after the last pass is discarded, so the output total is the input total plus the excess minus that remainder.
- R8: `done_o` rises at the end of the last pass. Then `NBINS` beats stream out on consecutive cycles in bin order, with `out_last_o` high on the final beat only. `done_o` stays high until the next start.
- R9: An accepted `start_i` clears `done_o` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a tile; captures excess and limit |
| excess_i | input | EXC_W | Total count removed by clipping |
| beta_i | input | CNT_W | Clip limit |
| in_valid_i | input | 1 | Input bin valid |
| in_count_i | input | CNT_W | Input bin count, ascending bin order |
| out_valid_o | output | 1 | Output bin valid |
| out_count_o | output | CNT_W | Redistributed bin count |
| out_last_o | output | 1 | Final output bin |
| done_o | output | 1 | Redistribution complete |

## Verification
The bench uses tiles where every bin already sits at the limit. A design that divides by a zero bin count there, or still adds the `+1`, would push bins over the limit. It uses tiles where bins close to the limit cap the first pass while distant bins keep absorbing units in the single-unit passes. A design with the wrong pass count, or one that skips the cap, gives wrong totals in exactly those bins. An oversized excess checks that the leftover is dropped rather than spilled past the limit. A zero-excess tile catches any pass that changes bins it should leave alone. Back-to-back tiles catch a done flag that fails to clear or a stale pool carried into the next tile.

// File: rtl/clahe_redist_pkg.sv
package clahe_redist_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_DIV,
      ST_PASS,
      ST_OUT
   } rd_state_e;
endpackage

// File: rtl/clahe_redist_div.sv
module clahe_redist_div #(
   parameter int W      = 24,
   parameter int SERIAL = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         done_o,
   output logic [W-1:0] quo_o
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0] num_q, den_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q <= '0;
         den_q <= '0;
      end else if (start_i) begin
         num_q <= num_i;
         den_q <= den_i;
      end
   end

   generate
      if (SERIAL != 0) begin : g_serial
         logic [W-1:0]  sh_q, q_q;
         logic [W:0]    rem_q, trial;
         logic [CW-1:0] cnt_q;
         logic          run_q, dn_q;

         assign trial = {rem_q[W-1:0], sh_q[W-1]};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q  <= '0;
               q_q   <= '0;
               rem_q <= '0;
               cnt_q <= '0;
               run_q <= 1'b0;
               dn_q  <= 1'b0;
            end else begin
               dn_q <= 1'b0;
               if (start_i) begin
                  sh_q  <= num_i;
                  q_q   <= '0;
                  rem_q <= '0;
                  cnt_q <= CW'(W);
                  run_q <= 1'b1;
               end else if (run_q) begin
                  if (trial >= {1'b0, den_q}) begin
                     rem_q <= trial - {1'b0, den_q};
                     q_q   <= {q_q[W-2:0], 1'b1};
                  end else begin
                     rem_q <= trial;
                     q_q   <= {q_q[W-2:0], 1'b0};
                  end
                  sh_q  <= sh_q << 1;
                  cnt_q <= cnt_q - 1'b1;
                  if (cnt_q == CW'(1)) begin
                     run_q <= 1'b0;
                     dn_q  <= 1'b1;
                  end
               end
            end
         end

         assign done_o = dn_q;
         assign quo_o  = q_q;
      end else begin : g_comb
         logic         dn_q;
         logic [W-1:0] q_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dn_q <= 1'b0;
               q_q  <= '0;
            end else begin
               dn_q <= start_i;
               if (start_i) q_q <= (den_i == '0) ? '0 : num_i / den_i;
            end
         end

         assign done_o = dn_q;
         assign quo_o  = q_q;
      end
   endgenerate

   // R3
   quo_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && den_q != '0) |->
         (({{W{1'b0}}, quo_o} * {{W{1'b0}}, den_q}) <= {{W{1'b0}}, num_q}) &&
         ((({{W{1'b0}}, quo_o} + 1'b1) * {{W{1'b0}}, den_q}) > {{W{1'b0}}, num_q}));
endmodule

// File: rtl/clahe_redist_alu.sv
module clahe_redist_alu #(
   parameter int CNT_W = 16,
   parameter int EXC_W = 24
) (
   input  logic             first_i,
   input  logic [CNT_W-1:0] h_i,
   input  logic [CNT_W-1:0] beta_i,
   input  logic [EXC_W-1:0] m_i,
   input  logic [EXC_W-1:0] pool_i,
   output logic [CNT_W-1:0] add_o
);
   logic [EXC_W:0] room, want, amt;

   always_comb begin
      room = (h_i < beta_i) ? (EXC_W+1)'(beta_i - h_i) : '0;
      want = first_i ? ({1'b0, m_i} + 1'b1) : (EXC_W+1)'(1);
      amt  = want;
      if (room < amt)             amt = room;
      if ({1'b0, pool_i} < amt)   amt = {1'b0, pool_i};
      add_o = amt[CNT_W-1:0];
   end
endmodule

// File: rtl/clahe_redist.sv
module clahe_redist
   import clahe_redist_pkg::*;
#(
   parameter int NBINS      = 256,
   parameter int CNT_W      = 16,
   parameter int EXC_W      = 24,
   parameter int NFILL      = 3,
   parameter int SERIAL_DIV = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [EXC_W-1:0] excess_i,
   input  logic [CNT_W-1:0] beta_i,
   input  logic             in_valid_i,
   input  logic [CNT_W-1:0] in_count_i,
   output logic             out_valid_o,
   output logic [CNT_W-1:0] out_count_o,
   output logic             out_last_o,
   output logic             done_o
);
   localparam int IDX_W = $clog2(NBINS);
   localparam int NBUF  = NFILL + 2;
   localparam int PW    = $clog2(NBUF);
   localparam int LASTB = NBUF - 1;

   generate
      if (NBINS < 2 || (1 << IDX_W) != NBINS) begin : g_bad_bins
         $error("NBINS must be a power of two, at least 2");
      end
      if (EXC_W < CNT_W + IDX_W) begin : g_bad_exc
         $error("EXC_W too narrow for a full tile excess");
      end
      if (NFILL < 1) begin : g_bad_fill
         $error("NFILL must be at least 1");
      end
   endgenerate

   rd_state_e        state_q;
   logic [IDX_W-1:0] idx_q;
   logic [PW-1:0]    pass_q, pass_nx;
   logic [CNT_W-1:0] beta_q;
   logic [EXC_W-1:0] exc_q, m_q, pool_q;
   logic [IDX_W:0]   atlim_q, free_bins;
   logic             done_q, div_go_q, div_done, idx_last;
   logic             ov_q, ol_q;
   logic [CNT_W-1:0] oc_q, h_cur, add;
   logic [EXC_W-1:0] quo;

   logic [CNT_W-1:0] bufs [NBUF][NBINS];

   assign pass_nx   = pass_q + 1'b1;
   assign idx_last  = (idx_q == IDX_W'(NBINS - 1));
   assign free_bins = (IDX_W+1)'(NBINS) - atlim_q;
   assign h_cur     = bufs[pass_q][idx_q];

   clahe_redist_div #(.W(EXC_W), .SERIAL(SERIAL_DIV)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_go_q),
      .num_i   (exc_q),
      .den_i   (EXC_W'(free_bins)),
      .done_o  (div_done),
      .quo_o   (quo)
   );

   clahe_redist_alu #(.CNT_W(CNT_W), .EXC_W(EXC_W)) u_alu (
      .first_i (pass_q == '0),
      .h_i     (h_cur),
      .beta_i  (beta_q),
      .m_i     (m_q),
      .pool_i  (pool_q),
      .add_o   (add)
   );

   always_ff @(posedge clk) begin
      if (state_q == ST_LOAD && in_valid_i) bufs[0][idx_q] <= in_count_i;
      if (state_q == ST_PASS) bufs[pass_nx][idx_q] <= h_cur + add;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         pass_q   <= '0;
         beta_q   <= '0;
         exc_q    <= '0;
         m_q      <= '0;
         pool_q   <= '0;
         atlim_q  <= '0;
         done_q   <= 1'b0;
         div_go_q <= 1'b0;
         ov_q     <= 1'b0;
         ol_q     <= 1'b0;
         oc_q     <= '0;
      end else begin
         div_go_q <= 1'b0;
         ov_q     <= 1'b0;
         ol_q     <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               exc_q   <= excess_i;
               beta_q  <= beta_i;
               idx_q   <= '0;
               atlim_q <= '0;
               done_q  <= 1'b0;
               state_q <= ST_LOAD;
            end
            ST_LOAD: if (in_valid_i) begin
               if (in_count_i >= beta_q) atlim_q <= atlim_q + 1'b1;
               idx_q <= idx_q + 1'b1;
               if (idx_last) begin
                  div_go_q <= 1'b1;
                  state_q  <= ST_DIV;
               end
            end
            ST_DIV: if (div_done) begin
               m_q     <= (free_bins == '0) ? '0 : quo;
               pool_q  <= exc_q;
               pass_q  <= '0;
               idx_q   <= '0;
               state_q <= ST_PASS;
            end
            ST_PASS: begin
               pool_q <= pool_q - EXC_W'(add);
               idx_q  <= idx_q + 1'b1;
               if (idx_last) begin
                  if (pass_q == PW'(NFILL)) begin
                     done_q  <= 1'b1;
                     state_q <= ST_OUT;
                  end else begin
                     pass_q <= pass_nx;
                  end
               end
            end
            ST_OUT: begin
               ov_q  <= 1'b1;
               oc_q  <= bufs[PW'(LASTB)][idx_q];
               ol_q  <= idx_last;
               idx_q <= idx_q + 1'b1;
               if (idx_last) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign out_valid_o = ov_q;
   assign out_count_o = oc_q;
   assign out_last_o  = ol_q;
   assign done_o      = done_q;

   // R6
   cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PASS && add != '0) |->
         ({1'b0, h_cur} + {1'b0, add}) <= {1'b0, beta_q});

   // R5
   fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PASS && pass_q != '0) |-> add <= CNT_W'(1));

   // R7
   pool_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PASS) |=> pool_q <= $past(pool_q));

   // R8
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> state_q == ST_OUT);

   // R8
   last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last_o |-> (out_valid_o && done_o));

   // R9
   done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i) |=> !done_o);
endmodule

// File: tb/sim_clahe_redist.sv
module sim_clahe_redist;
   localparam int NB = 256;
   localparam int CW = 16;
   localparam int EW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [EW-1:0] excess = '0;
   logic [CW-1:0] beta = '0;
   logic          in_valid = 1'b0;
   logic [CW-1:0] in_count = '0;
   logic          out_valid, out_last, done;
   logic [CW-1:0] out_count;

   int errs = 0;
   int checks = 0;
   int hin [NB];
   int exp_h [NB];

   always #4 clk = ~clk;

   clahe_redist u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .excess_i   (excess),
      .beta_i     (beta),
      .in_valid_i (in_valid),
      .in_count_i (in_count),
      .out_valid_o(out_valid),
      .out_count_o(out_count),
      .out_last_o (out_last),
      .done_o     (done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic model(input int exc, input int lim);
      int free_n = 0;
      int m, pool;
      for (int i = 0; i < NB; i++) if (hin[i] < lim) free_n++;
      m = (free_n == 0) ? 0 : exc / free_n;
      pool = exc;
      for (int i = 0; i < NB; i++) begin
         int a;
         exp_h[i] = hin[i];
         if (hin[i] < lim) begin
            a = m + 1;
            if (lim - hin[i] < a) a = lim - hin[i];
            if (pool < a) a = pool;
            exp_h[i] += a;
            pool -= a;
         end
      end
      for (int p = 0; p < 3; p++)
         for (int i = 0; i < NB; i++)
            if (exp_h[i] < lim && pool > 0) begin
               exp_h[i]++;
               pool--;
            end
   endtask

   task automatic run(input string req, input int exc, input int lim);
      int beats = 0;
      int tmo = 0;
      model(exc, lim);
      @(negedge clk);
      start = 1'b1;
      excess = EW'(exc);
      beta = CW'(lim);
      for (int i = 0; i < NB; i++) begin
         @(negedge clk);
         if (i == 0) begin
            start = 1'b0;
            chk(done == 1'b0, "R9", "done after start", int'(done), 0);
         end
         in_valid = 1'b1;
         in_count = CW'(hin[i]);
      end
      @(negedge clk);
      in_valid = 1'b0;
      while (beats < NB && tmo < 20000) begin
         if (out_valid) begin
            chk(int'(out_count) == exp_h[beats], req,
                $sformatf("bin %0d", beats), int'(out_count), exp_h[beats]);
            chk(int'(out_count) <= lim, "R6",
                $sformatf("cap bin %0d", beats), int'(out_count), lim);
            chk(out_last == (beats == NB - 1), "R8",
                $sformatf("last flag bin %0d", beats), int'(out_last),
                int'(beats == NB - 1));
            chk(done == 1'b1, "R8", "done while streaming", int'(done), 1);
            beats++;
         end
         @(negedge clk);
         tmo++;
      end
      chk(beats == NB, "R8", "beat count", beats, NB);
      chk(out_valid == 1'b0, "R8", "valid after last", int'(out_valid), 0);
      chk(done == 1'b1, "R8", "done held", int'(done), 1);
   endtask

   task automatic t_reset();
      chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
      chk(out_last == 1'b0, "R1", "reset out_last", int'(out_last), 0);
      chk(done == 1'b0, "R1", "reset done", int'(done), 0);
   endtask

   task automatic t_zero_excess();
      for (int i = 0; i < NB; i++) hin[i] = (i * 7) % 20;
      run("R2", 0, 30);
   endtask

   task automatic t_even_spread();
      for (int i = 0; i < NB; i++) hin[i] = 10;
      run("R3", 1024, 40);
   endtask

   task automatic t_cap_near_limit();
      for (int i = 0; i < NB; i++) hin[i] = 50 - (i % 4);
      run("R4", 300, 50);
   endtask

   task automatic t_all_at_limit();
      for (int i = 0; i < NB; i++) hin[i] = 20;
      run("R3", 100, 20);
   endtask

   task automatic t_fill_passes();
      for (int i = 0; i < NB; i++) hin[i] = (i % 2 == 0) ? 0 : 18;
      run("R5", 2000, 20);
   endtask

   task automatic t_overflow();
      for (int i = 0; i < NB; i++) hin[i] = 0;
      run("R7", 5000, 5);
   endtask

   task automatic t_back_to_back();
      for (int i = 0; i < NB; i++) hin[i] = i % 9;
      run("R9", 700, 9);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_excess();
      t_even_spread();
      t_cap_near_limit();
      t_all_at_limit();
      t_fill_passes();
      t_overflow();
      t_back_to_back();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule